// File: doc/BRIEF.md
# SMBus Register Slave Interface

This block is a two-wire bus target that lets a host read and write a small bank of byte-wide registers inside the chip. It oversamples the bus clock and data lines with the system clock, finds START, repeated-START and STOP conditions, and checks the 7-bit device address in the first byte of each transfer. A write transfer carries one register index byte and one data byte. A read transfer first sets the register index in a write phase, then uses a repeated START with the read bit set. The slave then returns one byte, most significant bit first.

The slave never drives the data line high. It only pulls SDA low to acknowledge or to send a zero, and it changes SDA only while SCL is low. The device address resets to 17h, so the first byte is 2Eh for a write and 2Fh for a read. The address sits in its own register at index 08h and can be rewritten over the bus. A separate timer reports when the bus is free and aborts a transfer when the host stops clocking for too long. All timeouts are counted in system clock cycles.

Top module: `smb_reg_slave`

## Requirements
- R1: While reset is asserted and right after it is released: sdaOe is 0, busIdle is 0, every bank register reads 00h and the device address is 17h.
- R2: A STOP (SDA rising while SCL is high) ends any transfer and releases SDA. A START (SDA falling while SCL is high) restarts the address phase from any state, including in the middle of a transfer.
- R3: In a write transfer, the first byte carries the address in bits 7:1 and 0 in bit 0 (for example 2Eh). The register index byte and the data byte follow. The slave acknowledges each of the three bytes by holding SDA low during the ninth clock. It then stores the data in the indexed register, and the value appears on regBank byte lane (index*8+7 : index*8).
- R4: In a read transfer, a write phase first sets the index. A repeated START and the address with bit 0 = 1 (for example 2Fh) follow. The slave acknowledges and then shifts the register out MSB first, one bit per SCL clock. It releases SDA for the host's acknowledge bit.
- R5: If bits 7:1 of the first byte do not match the device address, the slave does not acknowledge. It leaves SDA released until the next START.
- R6: Indexes from NUM_REGS upward, other than 08h, are unimplemented. A read of such an index returns 00h, and a write to it changes no register.
- R7: Bits 6:0 of the register at index 08h hold the device address, and bit 7 reads as 0. Writing it changes the address that every following transfer must match.
- R8: After the single data byte of a write, further bytes are not acknowledged and are not stored.
- R9: The slave changes sdaOe only while SCL is low. The one exception is an abort on bus idle.
- R10: busIdle rises after SCL and SDA have both been high for T_BUF cycles since a STOP, or for T_HIGH_MAX cycles without a STOP. It falls when either line goes low. When it rises, any transfer in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |
| busIdle | output | 1 | Bus free indication from the timeout logic |
| regBank | output | NUM_REGS*8 | Contents of the implemented registers, index 0 in the low byte |

## Verification
A wrong control state shows up within one bus bit. The slave either misses an acknowledge or pulls the line during a clock it does not own. The host sees that at the next SCL high phase as a wrong ACK bit or a corrupted read bit. A wrong index pointer or a mis-shifted receive register shows up in regBank right after the data byte's falling edge. It also shows up in the byte returned by the next read. Timer errors appear as busIdle rising too early, or too late, against windows that have a few cycles of margin around the synchronizer delay.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ACK_A,
    S_REG,
    S_ACK_R,
    S_DATA,
    S_ACK_D,
    S_TX,
    S_RX_ACK,
    S_WAIT
  } ctrl_state_e;

  typedef struct packed {
    logic shiftIn;   // shift a sampled SDA bit into the receive byte
    logic loadPtr;   // take the received byte as register index
    logic writeReg;  // store the received byte at the index
    logic loadTx;    // fetch read data and drive its MSB
    logic shiftTx;   // advance read data and drive the next bit
    logic ackOn;     // pull SDA low for an acknowledge
    logic relSda;    // release SDA
  } dp_strobe_t;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int T_BUF      = 20,
  parameter int T_HIGH_MAX = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclSync,
  output logic sdaSync,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet,
  output logic busIdle
);
  localparam int CW = $clog2(T_HIGH_MAX + 1);
  localparam logic [CW-1:0] BUF_LIM  = CW'(T_BUF);
  localparam logic [CW-1:0] HIGH_LIM = CW'(T_HIGH_MAX);

  logic sclMeta, sdaMeta, sclPrev, sdaPrev;
  logic [CW-1:0] highCnt;
  logic sinceStop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclMeta <= 1'b1;
      sdaMeta <= 1'b1;
      sclSync <= 1'b1;
      sdaSync <= 1'b1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclMeta <= sclIn;
      sdaMeta <= sdaIn;
      sclSync <= sclMeta;
      sdaSync <= sdaMeta;
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt   <= '0;
      sinceStop <= 1'b0;
      busIdle   <= 1'b0;
    end else begin
      if (stopDet) sinceStop <= 1'b1;
      else if (startDet) sinceStop <= 1'b0;

      if (!(sclSync && sdaSync)) begin
        highCnt <= '0;
        busIdle <= 1'b0;
      end else begin
        if (highCnt != HIGH_LIM) highCnt <= highCnt + 1'b1;
        if ((sinceStop && highCnt >= BUF_LIM) || highCnt == HIGH_LIM)
          busIdle <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl
  import smb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclRise,
  input  logic        sclFall,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        busIdle,
  input  logic        addrMatch,
  input  logic        rwBit,
  output ctrl_state_e state,
  output dp_strobe_t  strb
);
  ctrl_state_e stNext;
  logic [3:0]  bitCnt, cntNext;
  logic        rwFlag, rwNext;

  always_comb begin
    stNext  = state;
    cntNext = bitCnt;
    rwNext  = rwFlag;
    strb    = '0;
    if (startDet) begin
      stNext      = S_ADDR;
      cntNext     = '0;
      strb.relSda = 1'b1;
    end else if (stopDet) begin
      stNext      = S_IDLE;
      strb.relSda = 1'b1;
    end else if (busIdle && state != S_IDLE) begin
      stNext      = S_IDLE;
      strb.relSda = 1'b1;
    end else begin
      unique case (state)
        S_ADDR, S_REG, S_DATA: begin
          if (sclRise && bitCnt != 4'd8) begin
            strb.shiftIn = 1'b1;
            cntNext      = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == 4'd8) begin
            cntNext = '0;
            if (state == S_ADDR) begin
              if (addrMatch) begin
                strb.ackOn = 1'b1;
                rwNext     = rwBit;
                stNext     = S_ACK_A;
              end else begin
                strb.relSda = 1'b1;
                stNext      = S_WAIT;
              end
            end else if (state == S_REG) begin
              strb.loadPtr = 1'b1;
              strb.ackOn   = 1'b1;
              stNext       = S_ACK_R;
            end else begin
              strb.writeReg = 1'b1;
              strb.ackOn    = 1'b1;
              stNext        = S_ACK_D;
            end
          end
        end
        S_ACK_A: if (sclFall) begin
          cntNext = '0;
          if (rwFlag) begin
            strb.loadTx = 1'b1;
            stNext      = S_TX;
          end else begin
            strb.relSda = 1'b1;
            stNext      = S_REG;
          end
        end
        S_ACK_R: if (sclFall) begin
          strb.relSda = 1'b1;
          cntNext     = '0;
          stNext      = S_DATA;
        end
        S_ACK_D: if (sclFall) begin
          strb.relSda = 1'b1;
          stNext      = S_WAIT;
        end
        S_TX: begin
          if (sclRise) begin
            cntNext = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              strb.relSda = 1'b1;
              stNext      = S_RX_ACK;
            end else begin
              strb.shiftTx = 1'b1;
            end
          end
        end
        S_RX_ACK: if (sclRise) stNext = S_WAIT;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      rwFlag <= 1'b0;
    end else begin
      state  <= stNext;
      bitCnt <= cntNext;
      rwFlag <= rwNext;
    end
  end

endmodule

// File: rtl/smb_datapath.sv
module smb_datapath
  import smb_pkg::*;
#(
  parameter int         NUM_REGS = 4,
  parameter logic [7:0] SA_IDX   = 8'h08,
  parameter logic [6:0] DEF_ADDR = 7'h17
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaSync,
  input  dp_strobe_t            strb,
  output logic                  addrMatch,
  output logic                  rwBit,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regBank
);
  localparam int IDXW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [7:0] REG_LIM = 8'(NUM_REGS);

  logic [7:0] rxByte, ptr, txByte, rdData;
  logic [6:0] devAddr;
  logic [7:0] regs [NUM_REGS];
  logic       ptrInBank;

  assign ptrInBank = ptr < REG_LIM;
  assign addrMatch = rxByte[7:1] == devAddr;
  assign rwBit     = rxByte[0];

  always_comb begin
    if (ptrInBank)           rdData = regs[ptr[IDXW-1:0]];
    else if (ptr == SA_IDX)  rdData = {1'b0, devAddr};
    else                     rdData = 8'h00;
  end

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gBank
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regs[g] <= '0;
        else if (strb.writeReg && ptrInBank && ptr[IDXW-1:0] == IDXW'(g))
          regs[g] <= rxByte;
      end
      assign regBank[g*8 +: 8] = regs[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte  <= '0;
      ptr     <= '0;
      txByte  <= '0;
      devAddr <= DEF_ADDR;
      sdaOe   <= 1'b0;
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[6:0], sdaSync};
      if (strb.loadPtr) ptr <= rxByte;
      if (strb.writeReg && ptr == SA_IDX) devAddr <= rxByte[6:0];
      if (strb.loadTx) txByte <= rdData;
      else if (strb.shiftTx) txByte <= {txByte[6:0], 1'b0};

      if (strb.relSda)       sdaOe <= 1'b0;
      else if (strb.ackOn)   sdaOe <= 1'b1;
      else if (strb.loadTx)  sdaOe <= ~rdData[7];
      else if (strb.shiftTx) sdaOe <= ~txByte[6];
    end
  end

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
  import smb_pkg::*;
#(
  parameter int         NUM_REGS   = 4,
  parameter logic [7:0] SA_IDX     = 8'h08,
  parameter logic [6:0] DEF_ADDR   = 7'h17,
  parameter int         T_BUF      = 20,
  parameter int         T_HIGH_MAX = 100
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic                  busIdle,
  output logic [NUM_REGS*8-1:0] regBank
);
  logic sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic addrMatch, rwBit;
  ctrl_state_e ctrlState;
  dp_strobe_t  strb;

  smb_sync #(.T_BUF(T_BUF), .T_HIGH_MAX(T_HIGH_MAX)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .busIdle(busIdle)
  );

  smb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .busIdle(busIdle),
    .addrMatch(addrMatch), .rwBit(rwBit), .state(ctrlState), .strb(strb)
  );

  smb_datapath #(.NUM_REGS(NUM_REGS), .SA_IDX(SA_IDX), .DEF_ADDR(DEF_ADDR)) uDp (
    .clk(clk), .rstN(rstN), .sdaSync(sdaSync), .strb(strb),
    .addrMatch(addrMatch), .rwBit(rwBit), .sdaOe(sdaOe), .regBank(regBank)
  );

endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk
  import smb_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic                  busIdle,
  input logic [NUM_REGS*8-1:0] regBank,
  input ctrl_state_e           ctrlState,
  input logic                  stopDet,
  input logic                  sclSync,
  input logic                  sdaSync
);
  // R9: the slave only moves SDA while the bus clock is low
  a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !busIdle) |-> !sclIn);

  // R3: register updates land in the low phase of the clock
  a_r3_bank_update_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regBank) |-> !sclIn);

  // R2: a detected STOP leaves the controller waiting for a START
  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> ctrlState == S_IDLE);

  // R5: no drive while unaddressed or idle
  a_r5_released_when_waiting: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == S_IDLE || ctrlState == S_WAIT) |-> !sdaOe);

  // R10: busIdle only follows a cycle with both lines high
  a_r10_idle_needs_high: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> $past(sclSync && sdaSync));

endmodule

bind smb_reg_slave smb_reg_slave_chk #(.NUM_REGS(NUM_REGS)) uChk (.*);

// File: tb/smb_reg_slave_test.sv
module smb_reg_slave_test;
  localparam int NREG = 4;
  localparam int TBUF = 20;
  localparam int THMX = 100;
  localparam int Q = 6;
  localparam int H = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic scl = 1'b1, sdaHost = 1'b1;
  logic sdaOe, busIdle;
  logic [NREG*8-1:0] regBank;
  logic sdaLine;
  int nChecks = 0, nErr = 0, cyc = 0, drvCnt = 0, badMove = 0;
  logic prevOe = 1'b0;

  assign sdaLine = sdaHost & ~sdaOe;

  smb_reg_slave #(.NUM_REGS(NREG), .T_BUF(TBUF), .T_HIGH_MAX(THMX)) uut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .busIdle(busIdle), .regBank(regBank)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (sdaOe) drvCnt++;
    if (rstN && sdaOe !== prevOe && scl && !busIdle) badMove++;
    prevOe = sdaOe;
  end

  initial begin
    wait (cyc > 150000);
    nErr++;
    $display("FAIL R2 watchdog: cycles=%0d expected < 150000", cyc);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks + 1);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();  // also used as repeated START
    sdaHost = 1'b1; w(Q); scl = 1'b1; w(Q);
    sdaHost = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic busStop();
    sdaHost = 1'b0; w(Q); scl = 1'b1; w(Q);
    sdaHost = 1'b1; w(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaHost = b[i]; w(Q); scl = 1'b1; w(H); scl = 1'b0; w(Q);
    end
    sdaHost = 1'b1; w(Q); scl = 1'b1; w(H/2);
    ack = sdaLine; w(H/2); scl = 1'b0; w(Q);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    sdaHost = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1'b1; w(H/2); b[i] = sdaLine; w(H/2); scl = 1'b0;
    end
    w(Q); sdaHost = nack; scl = 1'b1; w(H); scl = 1'b0; w(Q);
  endtask

  task automatic doWrite(input logic [6:0] a, input logic [7:0] idx, input logic [7:0] d,
                         output logic [2:0] acks);
    busStart();
    sendByte({a, 1'b0}, acks[2]);
    sendByte(idx, acks[1]);
    sendByte(d, acks[0]);
    busStop();
  endtask

  task automatic doRead(input logic [6:0] a, input logic [7:0] idx,
                        output logic [2:0] acks, output logic [7:0] d);
    busStart();
    sendByte({a, 1'b0}, acks[2]);
    sendByte(idx, acks[1]);
    busStart();
    sendByte({a, 1'b1}, acks[0]);
    recvByte(1'b1, d);
    busStop();
  endtask

  typedef struct packed {
    logic [7:0] idx;
    logic [7:0] wdat;
    logic [7:0] rexp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'h00, 8'hA5, 8'hA5},
    '{8'h03, 8'h3C, 8'h3C},
    '{8'h05, 8'h77, 8'h00},
    '{8'h01, 8'hFF, 8'hFF},
    '{8'h02, 8'h01, 8'h01}
  };

  logic [7:0] model [NREG];
  logic [NREG*8-1:0] expBank;

  function automatic logic [NREG*8-1:0] packModel();
    logic [NREG*8-1:0] r;
    for (int k = 0; k < NREG; k++) r[k*8 +: 8] = model[k];
    return r;
  endfunction

  initial begin
    logic [2:0] acks;
    logic [7:0] rd;
    logic a0;
    for (int k = 0; k < NREG; k++) model[k] = 8'h00;

    w(4);
    chk("R1 sdaOe in reset", {31'b0, sdaOe}, 0);
    rstN = 1'b1;
    w(2);
    chk("R1 sdaOe after reset", {31'b0, sdaOe}, 0);
    chk("R1 busIdle after reset", {31'b0, busIdle}, 0);
    chk("R1 bank after reset", regBank, 0);

    // R1/R7: address register reads reset address 17h
    doRead(7'h17, 8'h08, acks, rd);
    chk("R7 read address reg acks", {29'b0, acks}, 0);
    chk("R1 reset address value", {24'b0, rd}, 32'h17);

    // table walk: R3 write, R4 read, R6 unimplemented
    for (int v = 0; v < 5; v++) begin
      doWrite(7'h17, VECS[v].idx, VECS[v].wdat, acks);
      chk("R3 write acks", {29'b0, acks}, 0);
      if (VECS[v].idx < NREG) model[VECS[v].idx] = VECS[v].wdat;
      expBank = packModel();
      chk("R3 R6 bank after write", regBank, expBank);
      doRead(7'h17, VECS[v].idx, acks, rd);
      chk("R4 read acks", {29'b0, acks}, 0);
      chk("R4 R6 read data", {24'b0, rd}, {24'b0, VECS[v].rexp});
    end

    // R10: free-bus time after the last STOP
    w(5);
    chk("R10 idle too early after stop", {31'b0, busIdle}, 0);
    w(TBUF + 10);
    chk("R10 idle after free time", {31'b0, busIdle}, 1);
    scl = 1'b0; w(6);
    chk("R10 idle drops on low line", {31'b0, busIdle}, 0);
    scl = 1'b1; w(4);

    // R5: mismatched address, no drive for the rest of the transfer
    drvCnt = 0;
    doWrite(7'h22, 8'h00, 8'h5A, acks);
    chk("R5 mismatch acks", {29'b0, acks}, 3'b111);
    chk("R5 no drive on mismatch", drvCnt, 0);
    chk("R5 bank untouched", regBank, packModel());

    // R8: extra byte after the data byte
    busStart();
    sendByte(8'h2E, a0); chk("R8 address ack", {31'b0, a0}, 0);
    sendByte(8'h02, a0); chk("R8 index ack", {31'b0, a0}, 0);
    sendByte(8'h11, a0); chk("R8 data ack", {31'b0, a0}, 0);
    sendByte(8'h99, a0); chk("R8 extra byte nack", {31'b0, a0}, 1);
    busStop();
    model[2] = 8'h11;
    chk("R8 bank holds first byte only", regBank, packModel());

    // R2: START in mid-byte restarts the address phase
    busStart();
    sendByte(8'h2E, a0);
    for (int i = 0; i < 3; i++) begin
      sdaHost = 1'b0; w(Q); scl = 1'b1; w(H); scl = 1'b0; w(Q);
    end
    busStart();
    sendByte(8'h2E, a0); chk("R2 restart address ack", {31'b0, a0}, 0);
    sendByte(8'h03, a0);
    sendByte(8'h66, a0); chk("R2 restart data ack", {31'b0, a0}, 0);
    busStop();
    model[3] = 8'h66;
    chk("R2 restart write lands", regBank, packModel());

    // R7: change the device address
    doWrite(7'h17, 8'h08, 8'h22, acks);
    chk("R7 address write acks", {29'b0, acks}, 0);
    doWrite(7'h17, 8'h00, 8'h44, acks);
    chk("R7 old address nacked", {29'b0, acks}, 3'b111);
    doRead(7'h22, 8'h08, acks, rd);
    chk("R7 new address acks", {29'b0, acks}, 0);
    chk("R7 address readback", {24'b0, rd}, 32'h22);
    doRead(7'h22, 8'h00, acks, rd);
    chk("R7 bank via new address", {24'b0, rd}, {24'b0, model[0]});

    // R10: stuck-high timeout with no STOP aborts the transfer
    busStart();
    for (int i = 0; i < 3; i++) begin
      sdaHost = 1'b0; w(Q); scl = 1'b1; w(H); scl = 1'b0; w(Q);
    end
    sdaHost = 1'b1; w(Q); scl = 1'b1;
    w(TBUF + 10);
    chk("R10 no early idle without stop", {31'b0, busIdle}, 0);
    w(THMX);
    chk("R10 idle after max high time", {31'b0, busIdle}, 1);
    doWrite(7'h22, 8'h01, 8'h5C, acks);
    chk("R10 transfer after abort", {29'b0, acks}, 0);
    model[1] = 8'h5C;
    chk("R10 bank after abort", regBank, packModel());

    chk("R9 sda moved while scl high", badMove, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule